// File: doc/BRIEF.md
# Dual-Channel Elastic Sample FIFO with Collision Fault

This block sits between a sample source running on its own write clock and a converter datapath running on a read clock. Both sides run at the same nominal sample rate. It stores complex sample pairs, a 16-bit I word and a 16-bit Q word per entry, in an eight-entry ring. Its job is to absorb the phase drift between the two clocks.

There is no full or empty handshake. The write side stores a pair and steps its pointer whenever `wr_en` is high. The read side fetches a pair and steps its own pointer whenever `rd_en` is high. After reset the write pointer sits half the ring ahead of the read pointer.

The write pointer crosses to the read side as a Gray code through two flops. There it is compared with the read pointer. The difference is offered as a level output. When the difference reaches zero, the read side can no longer trust the data, because the ring has either run dry or been overrun. A sticky fault is then raised and the read outputs are muted. The fault stays set until software clears it or a reset occurs.

Top module: `iq_elastic_fifo`

## Requirements
- R1: Pairs are read out in the order they were written. Each read returns the I and Q words stored together, and the ring holds eight entries.
- R2: After both resets the level reads 4, the fault is 0, and `rd_i` and `rd_q` are 0.
- R3: The write pointer steps only on a write-clock edge with `wr_en` high. The read pointer steps only on a read-clock edge with `rd_en` high. The read data updates on the edge that performs the read and holds while `rd_en` is low.
- R4: `level` equals the write pointer as seen in the read domain minus the read pointer, modulo 8. A write becomes visible in `level` two read-clock edges after the write edge, and the synchronized Gray code changes at most one bit per edge.
- R5: When `level` is 0 at a read-clock edge, the fault is 1 after that edge. A level of 7 or less without reaching 0 never raises it.
- R6: The fault is sticky. A `fault_clr` pulse clears it only if `level` is non-zero at that edge. If a collision is present, the set wins.
- R7: While the fault is 1, `rd_i` and `rd_q` read 0. The last fetched pair is kept and reappears once the fault is cleared.
- R8: Asserting both resets removes a standing fault and restores the half-ring gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Store one pair and step the write pointer |
| wr_i | input | 16 | I word to store |
| wr_q | input | 16 | Q word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Fetch one pair and step the read pointer |
| fault_clr | input | 1 | Clear request for the sticky fault |
| rd_i | output | 16 | Fetched I word, zero while faulted |
| rd_q | output | 16 | Fetched Q word, zero while faulted |
| level | output | 3 | Synchronized pointer spacing |
| fault | output | 1 | Sticky pointer-collision flag |

## Verification
The one-bit-per-edge check on the synchronized Gray pointer assumes that the write clock is no faster than the read clock. It also assumes that both resets are released together. The stimulus drives both domains from one shared clock, so every pointer step crosses the synchronizer deterministically. The bench only releases the resets as a pair. It approaches collision from both sides: by draining reads past the last write, and by overrunning with writes. The expected fault timing includes the two synchronizer stages.

// File: rtl/iq_elastic_fifo.sv
module iq_elastic_fifo #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_i,
  input  logic [W-1:0]  wr_q,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  input  logic          fault_clr,
  output logic [W-1:0]  rd_i,
  output logic [W-1:0]  rd_q,
  output logic [AW-1:0] level,
  output logic          fault
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] GAP = AW'(DEPTH / 2);

  function automatic logic [AW-1:0] b2g(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int k = AW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [2*W-1:0] mem [DEPTH];
  logic [AW-1:0]  wbin, wgray, ws1, ws2, rbin;
  logic [2*W-1:0] rdata;
  logic           fault_q;
  logic [AW-1:0]  wnext;

  assign wnext = wbin + AW'(1);

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wbin  <= GAP;
      wgray <= b2g(GAP);
    end else if (wr_en) begin
      wbin  <= wnext;
      wgray <= b2g(wnext);
    end

  always_ff @(posedge wr_clk)
    if (wr_en) mem[wbin] <= {wr_i, wr_q};

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      ws1 <= b2g(GAP);
      ws2 <= b2g(GAP);
    end else begin
      ws1 <= wgray;
      ws2 <= ws1;
    end

  assign level = g2b(ws2) - rbin;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rbin    <= '0;
      rdata   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (rd_en) begin
        rdata <= mem[rbin];
        rbin  <= rbin + AW'(1);
      end
      fault_q <= (fault_q & ~fault_clr) | (level == '0);
    end

  assign fault = fault_q;
  assign rd_i  = fault_q ? '0 : rdata[2*W-1:W];
  assign rd_q  = fault_q ? '0 : rdata[W-1:0];

  AST_COLLISION_SETS: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (level == '0) |=> fault); // R5
  AST_FAULT_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (fault && !fault_clr) |=> fault); // R6
  AST_FAULT_CLEAR_CAUSE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(fault) |-> $past(fault_clr)); // R6
  AST_MUTED_OUTPUT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    fault |-> (rd_i == '0 && rd_q == '0)); // R7
  AST_GRAY_ONE_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
    $onehot0(ws2 ^ $past(ws2))); // R4
  AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_en |=> $stable(wgray)); // R3
endmodule

// File: tb/iq_elastic_fifo_bench.sv
module iq_elastic_fifo_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, fault_clr = 1'b0;
  logic [15:0] wr_i = '0, wr_q = '0;
  logic [15:0] rd_i, rd_q;
  logic [2:0]  level;
  logic        fault;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  iq_elastic_fifo u_iq_elastic_fifo (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .fault_clr(fault_clr),
    .rd_i(rd_i), .rd_q(rd_q), .level(level), .fault(fault));

  localparam logic [31:0] VEC [12] = '{
    32'h1111_AAAA, 32'h2222_BBBB, 32'h3333_CCCC, 32'h4444_DDDD,
    32'h0001_8000, 32'hFFFF_0000, 32'h7FFF_8001, 32'h5A5A_A5A5,
    32'h0F0F_F0F0, 32'h1234_5678, 32'hDEAD_BEEF, 32'hCAFE_F00D};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step();
    step();
    chk("R2 level", 32'(level), 32'd4);
    chk("R2 fault", 32'(fault), 32'd0);
    chk("R2 data", {rd_i, rd_q}, 32'd0);
    rst_n = 1'b1;
    step();

    for (int n = 0; n < 12; n++) begin
      wr_en = 1'b1;
      rd_en = 1'b1;
      {wr_i, wr_q} = VEC[n];
      step();
      if (n >= 4) chk("R1 stream order", {rd_i, rd_q}, VEC[n-4]);
      if (n >= 1) chk("R4 streaming level", 32'(level), 32'd2);
      chk("R5 no fault while streaming", 32'(fault), 32'd0);
    end

    wr_en = 1'b0;
    rd_en = 1'b0;
    step();
    step();
    chk("R4 level after sync", 32'(level), 32'd4);
    chk("R3 hold without read", {rd_i, rd_q}, VEC[7]);

    for (int k = 0; k < 4; k++) begin
      rd_en = 1'b1;
      step();
      chk("R1 drain order", {rd_i, rd_q}, VEC[8+k]);
      chk("R4 drain level", 32'(level), 32'(3 - k));
    end
    chk("R5 fault one edge late", 32'(fault), 32'd0);
    rd_en = 1'b0;
    step();
    chk("R5 underrun fault", 32'(fault), 32'd1);
    chk("R7 muted output", {rd_i, rd_q}, 32'd0);

    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;
    chk("R6 collision beats clear", 32'(fault), 32'd1);

    wr_en = 1'b1;
    {wr_i, wr_q} = 32'h0BAD_0BAD;
    step();
    wr_en = 1'b0;
    step();
    step();
    chk("R4 level one", 32'(level), 32'd1);
    chk("R6 sticky", 32'(fault), 32'd1);
    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;
    chk("R6 cleared", 32'(fault), 32'd0);
    chk("R7 data kept under mute", {rd_i, rd_q}, VEC[11]);

    for (int k = 0; k < 6; k++) begin
      wr_en = 1'b1;
      {wr_i, wr_q} = 32'(k);
      step();
    end
    wr_en = 1'b0;
    step();
    step();
    step();
    chk("R4 level seven", 32'(level), 32'd7);
    chk("R5 no fault at seven", 32'(fault), 32'd0);
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    step();
    chk("R4 sync stage one", 32'(level), 32'd7);
    step();
    chk("R4 overrun visible", 32'(level), 32'd0);
    chk("R5 fault not yet", 32'(fault), 32'd0);
    step();
    chk("R5 overrun fault", 32'(fault), 32'd1);

    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk("R8 reset clears fault", 32'(fault), 32'd0);
    chk("R8 gap restored", 32'(level), 32'd4);
    step();
    step();
    step();
    chk("R8 stays clear", 32'(fault), 32'd0);

    finish_run();
  end
endmodule